// File: doc/BRIEF.md
# Power Mode and Wakeup Controller

This block steps a chip between four operating modes: full speed on the PLL clock, a low-speed mode on the slow oscillator with the PLL turned off, an idle mode in which only the processor clock is stopped, and a power-off mode in which the core supply and every peripheral are shut down. Software asks for a mode by writing a small register interface. The block then drives a PLL enable, a clock source select, a processor clock gate, one clock gate per peripheral and a core power enable. The PLL and the power switch are modelled only as enables with a lock input and a power-good input.

Whenever the PLL has been off (leaving slow mode, or after a power-off wake), the block turns the PLL back on and keeps the oscillator selected. It returns to the PLL clock only when the lock input rises or a programmable count runs out. Idle ends on any enabled interrupt. Power-off ends only on an enabled external interrupt line (16 of them) or the real-time-clock alarm. The source that woke the chip is latched in a status register.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is full speed: pll_en, clk_sel_pll, cpu_clk_en and core_pwr_en are 1, all peripheral gates are 1, and the status register (address 3: bits [2:0] state code, bit 3 busy) reads 0.
- R2: Writing 1 to the mode register (address 0, bits [1:0]: 0 full speed, 1 slow, 2 idle, 3 power-off) in full-speed mode gives pll_en=0, clk_sel_pll=0 and cpu_clk_en=1 from the next cycle, with state code 1.
- R3: Writing 0 in slow mode sets pll_en=1 at once while clk_sel_pll stays 0 and busy is 1 (state code 5). With the lock input low this lasts exactly L+1 cycles, where L is the lock limit register (address 2). With the lock input high it lasts one cycle.
- R4: Writing 2 in full-speed mode gives cpu_clk_en=0 while pll_en, clk_sel_pll and the peripheral gates keep their values (state code 2).
- R5: In idle, an interrupt whose mask bit is 1 sets cpu_clk_en=1 in the cycle after the clock edge that samples it. The wake mask is at address 5: bits [15:0] are external lines, bit 16 is the alarm, bit 17 is the other-interrupt input, and it resets to all ones. A masked interrupt leaves cpu_clk_en at 0.
- R6: Writing 3 in full-speed or slow mode gives core_pwr_en=0, cpu_clk_en=0, pll_en=0 and all peripheral gates 0 (state code 3).
- R7: In power-off only an enabled external line or the enabled alarm wakes the block. The other-interrupt input and masked sources leave core_pwr_en at 0.
- R8: A power-off wake sets core_pwr_en=1 with cpu_clk_en=0, pll_en=0, gates 0 and busy=1 (state code 4) until power-good is 1. The PLL relock of R3 follows, with cpu_clk_en=1, and then full-speed mode.
- R9: The wake status register (address 4: bits [15:0] external lines, bit 16 alarm) holds the enabled sources that caused the last power-off wake. It is cleared on entry to power-off and reads 0 after reset.
- R10: The peripheral enable register (address 1, one bit per peripheral, reset all ones) drives the peripheral gates in full-speed, slow, idle and relock states.
- R11: A mode write during a transition (busy) is ignored, and so is an idle request made in slow mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| eint | input | 16 | External interrupt lines |
| rtc_alarm | input | 1 | Real-time-clock alarm |
| irq_other | input | 1 | Any other interrupt (wakes idle only) |
| pll_lock | input | 1 | PLL lock indication |
| pwr_ready | input | 1 | Core supply power-good |
| pll_en | output | 1 | PLL enable |
| clk_sel_pll | output | 1 | 1 selects PLL clock, 0 the slow oscillator |
| cpu_clk_en | output | 1 | Processor clock gate |
| periph_clk_en | output | NPERIPH | Per-peripheral clock gates |
| core_pwr_en | output | 1 | Core power enable |

## Verification
Assertions check on every cycle that the PLL clock is never selected while the PLL is off, and that it is only picked after a cycle with the PLL already enabled. They also check that a powered-down core has every gate closed, that power stays off with no enabled external or alarm wake, that power always returns with the processor clock held, and that an enabled interrupt in idle reopens the processor clock one cycle later. The exact relock duration against the lock limit, the ignoring of requests while busy, the wake status contents and their clearing, and the ordered power-up path are shown only by the bench's directed scenarios.

// File: rtl/pmc_pkg.sv
// Shared types and constants for the power mode controller.
// Assumes the external interrupt count is fixed at 16 by the wake map.
package pmc_pkg;
    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_SLOW   = 3'd1,
        ST_IDLE   = 3'd2,
        ST_OFF    = 3'd3,
        ST_PWRUP  = 3'd4,
        ST_RELOCK = 3'd5
    } pm_state_e;

    localparam logic [1:0] REQ_NORMAL = 2'd0;
    localparam logic [1:0] REQ_SLOW   = 2'd1;
    localparam logic [1:0] REQ_IDLE   = 2'd2;
    localparam logic [1:0] REQ_OFF    = 2'd3;

    localparam logic [2:0] A_MODE  = 3'd0;
    localparam logic [2:0] A_CLKEN = 3'd1;
    localparam logic [2:0] A_LOCK  = 3'd2;
    localparam logic [2:0] A_STAT  = 3'd3;
    localparam logic [2:0] A_WAKE  = 3'd4;
    localparam logic [2:0] A_MASK  = 3'd5;

    localparam int N_EXT  = 16;
    localparam int WAKE_W = N_EXT + 1;
    localparam int MASK_W = N_EXT + 2;
endpackage

// File: rtl/pmc_regs.sv
// Register file of the power mode controller: mode request strobe,
// peripheral enables, lock limit, wake mask, wake status and readback.
// Assumes NPERIPH and LOCK_W are at most 32 and reads are side-effect free.
module pmc_regs
    import pmc_pkg::*;
#(
    parameter int          NPERIPH  = 8,
    parameter int          LOCK_W   = 16,
    parameter logic [LOCK_W-1:0] LOCK_RST = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  pm_state_e          state,
    input  logic               wake_cap,
    input  logic [WAKE_W-1:0]  wake_vec,
    input  logic               off_enter,
    output logic               req_vld,
    output logic [1:0]         req_mode,
    output logic [NPERIPH-1:0] clk_en_q,
    output logic [LOCK_W-1:0]  lock_lim_q,
    output logic [MASK_W-1:0]  mask_q
);
    logic [WAKE_W-1:0] wake_q;
    logic              busy;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign busy         = (state == ST_PWRUP) || (state == ST_RELOCK);

    // Mode request is passed straight to the sequencer in the write cycle.
    assign req_vld  = reg_we && (reg_addr == A_MODE);
    assign req_mode = reg_wdata[1:0];

    // Writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en_q   <= '1;
            lock_lim_q <= LOCK_RST;
            mask_q     <= '1;
        end else if (reg_we) begin
            case (reg_addr)
                A_CLKEN: clk_en_q   <= reg_wdata[NPERIPH-1:0];
                A_LOCK:  lock_lim_q <= reg_wdata[LOCK_W-1:0];
                A_MASK:  mask_q     <= reg_wdata[MASK_W-1:0];
                default: ;
            endcase
        end
    end

    // Wake status: captured on a power-off wake, cleared on power-off entry.
    always_ff @(posedge clk) begin
        if (!rst_n)         wake_q <= '0;
        else if (off_enter) wake_q <= '0;
        else if (wake_cap)  wake_q <= wake_vec;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CLKEN: reg_rdata = 32'(clk_en_q);
            A_LOCK:  reg_rdata = 32'(lock_lim_q);
            A_STAT:  reg_rdata = {28'd0, busy, state};
            A_WAKE:  reg_rdata = 32'(wake_q);
            A_MASK:  reg_rdata = 32'(mask_q);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pmc_seq.sv
// Mode sequencer: steady modes, power-up wait and PLL relock with a
// lock-count timeout. Assumes wake inputs are already synchronous to clk.
module pmc_seq
    import pmc_pkg::*;
#(
    parameter int LOCK_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_vld,
    input  logic [1:0]         req_mode,
    input  logic [LOCK_W-1:0]  lock_lim,
    input  logic [MASK_W-1:0]  mask,
    input  logic [N_EXT-1:0]   eint,
    input  logic               rtc_alarm,
    input  logic               irq_other,
    input  logic               pll_lock,
    input  logic               pwr_ready,
    output pm_state_e          state,
    output logic               wake_cap,
    output logic [WAKE_W-1:0]  wake_vec,
    output logic               off_enter
);
    pm_state_e         nxt;
    logic [LOCK_W-1:0] lock_cnt;
    logic              wake_any;
    logic              relock_done;

    assign wake_vec    = {rtc_alarm, eint} & mask[WAKE_W-1:0];
    assign wake_any    = (|wake_vec) || (irq_other && mask[WAKE_W]);
    assign relock_done = pll_lock || (lock_cnt == lock_lim);
    assign wake_cap    = (state == ST_OFF) && (|wake_vec);
    assign off_enter   = (state != ST_OFF) && (nxt == ST_OFF);

    // Next-state selection for requests, wakes and handshakes.
    always_comb begin
        nxt = state;
        case (state)
            ST_NORMAL: if (req_vld) begin
                case (req_mode)
                    REQ_SLOW: nxt = ST_SLOW;
                    REQ_IDLE: nxt = ST_IDLE;
                    REQ_OFF:  nxt = ST_OFF;
                    default:  nxt = ST_NORMAL;
                endcase
            end
            ST_SLOW: if (req_vld) begin
                case (req_mode)
                    REQ_NORMAL: nxt = ST_RELOCK;
                    REQ_OFF:    nxt = ST_OFF;
                    default:    nxt = ST_SLOW;
                endcase
            end
            ST_IDLE:   if (wake_any)    nxt = ST_NORMAL;
            ST_OFF:    if (|wake_vec)   nxt = ST_PWRUP;
            ST_PWRUP:  if (pwr_ready)   nxt = ST_RELOCK;
            ST_RELOCK: if (relock_done) nxt = ST_NORMAL;
            default:   nxt = ST_NORMAL;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_NORMAL;
        else        state <= nxt;
    end

    // Lock counter: counts cycles spent in relock, zero elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_RELOCK) lock_cnt <= '0;
        else                              lock_cnt <= lock_cnt + 1'b1;
    end
endmodule

// File: rtl/pmc_gates.sv
// Output decode: turns the sequencer state into enables and clock gates.
// Assumes the gate outputs are consumed by glitch-free cells downstream.
module pmc_gates
    import pmc_pkg::*;
#(
    parameter int NPERIPH = 8
) (
    input  pm_state_e          state,
    input  logic [NPERIPH-1:0] clk_en,
    output logic               pll_en,
    output logic               clk_sel_pll,
    output logic               cpu_clk_en,
    output logic               core_pwr_en,
    output logic [NPERIPH-1:0] periph_clk_en
);
    // Per-state enable pattern.
    always_comb begin
        pll_en        = 1'b1;
        clk_sel_pll   = 1'b1;
        cpu_clk_en    = 1'b1;
        core_pwr_en   = 1'b1;
        periph_clk_en = clk_en;
        case (state)
            ST_SLOW: begin
                pll_en      = 1'b0;
                clk_sel_pll = 1'b0;
            end
            ST_IDLE:   cpu_clk_en = 1'b0;
            ST_OFF: begin
                pll_en        = 1'b0;
                clk_sel_pll   = 1'b0;
                cpu_clk_en    = 1'b0;
                core_pwr_en   = 1'b0;
                periph_clk_en = '0;
            end
            ST_PWRUP: begin
                pll_en        = 1'b0;
                clk_sel_pll   = 1'b0;
                cpu_clk_en    = 1'b0;
                periph_clk_en = '0;
            end
            ST_RELOCK: clk_sel_pll = 1'b0;
            default: ;
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Top of the power mode and wakeup controller. Connects the register file,
// the sequencer and the output decode. Assumes clk is always on.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int NPERIPH = 8,
    parameter int LOCK_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [15:0]        eint,
    input  logic               rtc_alarm,
    input  logic               irq_other,
    input  logic               pll_lock,
    input  logic               pwr_ready,
    output logic               pll_en,
    output logic               clk_sel_pll,
    output logic               cpu_clk_en,
    output logic [NPERIPH-1:0] periph_clk_en,
    output logic               core_pwr_en
);
    pm_state_e          state;
    logic               req_vld;
    logic [1:0]         req_mode;
    logic [NPERIPH-1:0] clk_en_q;
    logic [LOCK_W-1:0]  lock_lim;
    logic [MASK_W-1:0]  wake_mask;
    logic               wake_cap;
    logic [WAKE_W-1:0]  wake_vec;
    logic               off_enter;

    pmc_regs #(.NPERIPH(NPERIPH), .LOCK_W(LOCK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .state(state),
        .wake_cap(wake_cap), .wake_vec(wake_vec), .off_enter(off_enter),
        .req_vld(req_vld), .req_mode(req_mode), .clk_en_q(clk_en_q),
        .lock_lim_q(lock_lim), .mask_q(wake_mask)
    );

    pmc_seq #(.LOCK_W(LOCK_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_mode(req_mode),
        .lock_lim(lock_lim), .mask(wake_mask), .eint(eint),
        .rtc_alarm(rtc_alarm), .irq_other(irq_other), .pll_lock(pll_lock),
        .pwr_ready(pwr_ready), .state(state), .wake_cap(wake_cap),
        .wake_vec(wake_vec), .off_enter(off_enter)
    );

    pmc_gates #(.NPERIPH(NPERIPH)) u_gates (
        .state(state), .clk_en(clk_en_q), .pll_en(pll_en),
        .clk_sel_pll(clk_sel_pll), .cpu_clk_en(cpu_clk_en),
        .core_pwr_en(core_pwr_en), .periph_clk_en(periph_clk_en)
    );
endmodule

// File: rtl/pmc_checker.sv
// Property checker for pwr_mode_ctrl, attached with bind. Observes ports and
// the wake mask only; holds no state of its own.
module pmc_checker #(
    parameter int NPERIPH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [15:0]        eint,
    input logic               rtc_alarm,
    input logic               irq_other,
    input logic [17:0]        wake_mask,
    input logic               pll_en,
    input logic               clk_sel_pll,
    input logic               cpu_clk_en,
    input logic               core_pwr_en,
    input logic [NPERIPH-1:0] periph_clk_en
);
    logic ext_wake;
    logic any_wake;
    logic in_idle;

    assign ext_wake = |({rtc_alarm, eint} & wake_mask[16:0]);
    assign any_wake = ext_wake || (irq_other && wake_mask[17]);
    assign in_idle  = core_pwr_en && pll_en && !cpu_clk_en;

    // R3: the PLL clock is never selected with the PLL off.
    assert_sel_needs_pll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel_pll |-> pll_en);

    // R3: switching to the PLL clock follows a cycle with the PLL enabled.
    assert_switch_after_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_sel_pll) |-> $past(pll_en));

    // R6: a powered-down core has every gate closed.
    assert_off_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !core_pwr_en |-> (!cpu_clk_en && !pll_en && periph_clk_en == '0));

    // R7: without an enabled external or alarm wake, power stays off.
    assert_off_wake_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_pwr_en && !ext_wake) |=> !core_pwr_en);

    // R8: power returns with the processor clock held.
    assert_pwrup_cpu_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_pwr_en) |-> !cpu_clk_en);

    // R5: an enabled interrupt in idle reopens the processor clock next cycle.
    assert_idle_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && any_wake) |=> cpu_clk_en);
endmodule

bind pwr_mode_ctrl pmc_checker #(.NPERIPH(NPERIPH)) u_chk (
    .clk(clk), .rst_n(rst_n), .eint(eint), .rtc_alarm(rtc_alarm),
    .irq_other(irq_other), .wake_mask(wake_mask), .pll_en(pll_en),
    .clk_sel_pll(clk_sel_pll), .cpu_clk_en(cpu_clk_en),
    .core_pwr_en(core_pwr_en), .periph_clk_en(periph_clk_en)
);

// File: tb/sim_pwr_mode_ctrl.sv
// Directed bench for pwr_mode_ctrl: one task per scenario.
module sim_pwr_mode_ctrl;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [15:0]   eint = '0;
    logic          rtc_alarm = 1'b0;
    logic          irq_other = 1'b0;
    logic          pll_lock = 1'b0;
    logic          pwr_ready = 1'b0;
    logic          pll_en, clk_sel_pll, cpu_clk_en, core_pwr_en;
    logic [NP-1:0] periph_clk_en;

    int n_chk  = 0;
    int n_fail = 0;

    pwr_mode_ctrl #(.NPERIPH(NP), .LOCK_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eint(eint),
        .rtc_alarm(rtc_alarm), .irq_other(irq_other), .pll_lock(pll_lock),
        .pwr_ready(pwr_ready), .pll_en(pll_en), .clk_sel_pll(clk_sel_pll),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .core_pwr_en(core_pwr_en)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Enable pattern packed as {pll, sel, cpu, core}.
    function automatic logic [31:0] pins();
        return {28'd0, pll_en, clk_sel_pll, cpu_clk_en, core_pwr_en};
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(3'd3, d);
        chk("R1 status", d, 32'h0);
        chk("R1 enables", pins(), 32'hF);
        chk("R1 gates", 32'(periph_clk_en), 32'hFF);
        rd(3'd4, d);
        chk("R9 wake after reset", d, 32'h0);
    endtask

    task automatic t_slow();
        logic [31:0] d;
        wr(3'd0, 32'd1);
        chk("R2 slow enables", pins(), 32'h3);
        rd(3'd3, d);
        chk("R2 slow status", d, 32'h1);
    endtask

    task automatic t_relock_timeout();
        logic [31:0] d;
        int n = 0;
        wr(3'd2, 32'd5);
        pll_lock = 1'b0;
        wr(3'd0, 32'd0);
        chk("R3 relock pll on", pins(), 32'hB);
        rd(3'd3, d);
        chk("R3 relock busy", d, 32'hD);
        while (clk_sel_pll == 1'b0 && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R3 timeout length L+1", 32'(n), 32'd6);
        chk("R3 back to full speed", pins(), 32'hF);
    endtask

    task automatic t_relock_lock();
        wr(3'd0, 32'd1);
        pll_lock = 1'b1;
        wr(3'd0, 32'd0);
        chk("R3 lock relock first cycle", pins(), 32'hB);
        @(negedge clk);
        chk("R3 lock ends relock", pins(), 32'hF);
        pll_lock = 1'b0;
    endtask

    task automatic t_busy_ignore();
        logic [31:0] d;
        wr(3'd0, 32'd1);
        wr(3'd0, 32'd2);
        chk("R11 idle from slow ignored", pins(), 32'h3);
        wr(3'd2, 32'd20);
        wr(3'd0, 32'd0);
        wr(3'd0, 32'd1);
        rd(3'd3, d);
        chk("R11 request while busy ignored", d, 32'hD);
        chk("R11 pll kept on", pins(), 32'hB);
        for (int i = 0; i < 40 && clk_sel_pll == 1'b0; i++) @(negedge clk);
        chk("R11 relock completes", pins(), 32'hF);
        wr(3'd2, 32'd5);
    endtask

    task automatic t_periph();
        wr(3'd1, 32'hA5);
        chk("R10 gates full speed", 32'(periph_clk_en), 32'hA5);
        wr(3'd0, 32'd1);
        chk("R10 gates slow", 32'(periph_clk_en), 32'hA5);
        wr(3'd0, 32'd0);
        chk("R10 gates relock", 32'(periph_clk_en), 32'hA5);
        for (int i = 0; i < 20 && clk_sel_pll == 1'b0; i++) @(negedge clk);
    endtask

    task automatic t_idle();
        logic [31:0] d;
        wr(3'd0, 32'd2);
        chk("R4 idle enables", pins(), 32'hD);
        chk("R4 idle gates kept", 32'(periph_clk_en), 32'hA5);
        rd(3'd3, d);
        chk("R4 idle status", d, 32'h2);
        wr(3'd5, 32'h3FFF7);
        @(negedge clk);
        eint[3] = 1'b1;
        @(negedge clk);
        eint[3] = 1'b0;
        chk("R5 masked line ignored", 32'(cpu_clk_en), 32'h0);
        wr(3'd5, 32'h3FFFF);
        @(negedge clk);
        irq_other = 1'b1;
        #1 chk("R5 cpu closed before edge", 32'(cpu_clk_en), 32'h0);
        @(negedge clk);
        irq_other = 1'b0;
        chk("R5 cpu reopens next cycle", pins(), 32'hF);
    endtask

    task automatic t_off();
        logic [31:0] d;
        pwr_ready = 1'b0;
        wr(3'd0, 32'd3);
        chk("R6 off enables", pins(), 32'h0);
        chk("R6 off gates", 32'(periph_clk_en), 32'h0);
        irq_other = 1'b1;
        @(negedge clk);
        irq_other = 1'b0;
        @(negedge clk);
        chk("R7 other irq cannot wake", 32'(core_pwr_en), 32'h0);
        wr(3'd5, 32'h3FFDF);
        eint[5] = 1'b1;
        @(negedge clk);
        eint[5] = 1'b0;
        chk("R7 masked line cannot wake", 32'(core_pwr_en), 32'h0);
        wr(3'd5, 32'h3FFFF);
        eint[9] = 1'b1;
        @(negedge clk);
        eint[9] = 1'b0;
        chk("R8 power-up enables", pins(), 32'h1);
        chk("R8 power-up gates closed", 32'(periph_clk_en), 32'h0);
        rd(3'd3, d);
        chk("R8 power-up busy", d, 32'hC);
        repeat (3) @(negedge clk);
        chk("R8 waits for power good", pins(), 32'h1);
        pwr_ready = 1'b1;
        pll_lock  = 1'b1;
        @(negedge clk);
        chk("R8 relock after power good", pins(), 32'hB);
        @(negedge clk);
        chk("R8 back to full speed", pins(), 32'hF);
        pll_lock = 1'b0;
        rd(3'd4, d);
        chk("R9 wake source line 9", d, 32'h200);
        pwr_ready = 1'b0;
        wr(3'd0, 32'd3);
        rd(3'd4, d);
        chk("R9 cleared on entry", d, 32'h0);
        rtc_alarm = 1'b1;
        @(negedge clk);
        rtc_alarm = 1'b0;
        pwr_ready = 1'b1;
        pll_lock  = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 alarm wake completes", pins(), 32'hF);
        rd(3'd4, d);
        chk("R9 wake source alarm", d, 32'h10000);
        pll_lock = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_slow();
        t_relock_timeout();
        t_relock_lock();
        t_busy_ignore();
        t_periph();
        t_idle();
        t_off();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule